// File: doc/BRIEF.md
# Phase-Correct PWM Audio Generator

This block turns a stream of unsigned duty samples into a dual-slope pulse-width waveform. An external low-pass filter rebuilds the audio from it. An internal counter advances on every clock, so the timer runs at the system clock rate. It climbs from zero to its ceiling, then falls back to zero, and never holds either end for an extra clock. With the default 8-bit width, one period is 510 clocks, which gives about 15.7 kHz at an 8 MHz clock. The output is high in a window centred on the bottom of the count. A higher duty widens that window.

Each time the counter arrives back at zero, the block raises a one-clock period pulse. The producer uses this pulse to pace its next sample. Samples enter through a valid/ready port and wait in a one-entry holding stage. A held value reaches the comparator only when the counter is at its ceiling, so the waveform never changes shape partway through a half-period. The producer may hold `duty_valid_i` high for as long as it likes. A sample is taken only on a clock where `duty_ready_o` is also high. While a sample is waiting, ready stays low, and any value offered during that time is neither taken nor lost. Ready returns high on the clock after the waiting sample is applied at the ceiling.

Clearing the enable halts the generator. The counter and the active duty return to zero, and the output and the period pulse are forced low. A sample already waiting stays waiting. When the block is enabled again, the counter restarts from zero.

Top module: `pwm_audio_gen`

## Requirements
- R1: While enabled, period pulses occur exactly 2*(2^WIDTH-1) clocks apart (510 clocks at WIDTH=8), because the counter walks 0..255..0 with no dwell at either end.
- R2: The period pulse is high for exactly one clock. After the first clock edge with the enable high, the first pulse appears after exactly 510 clock edges.
- R3: With an active duty d, where 1 <= d <= 254, the output is high in each period for exactly 2*d clocks. Take offset 0 as the clock in which the period pulse is high. The output is then high at offsets 0..d, low from offset d+1 through 510-d, and high again from offset 511-d through 509.
- R4: An active duty of 0 keeps the output low for the whole period. An active duty of 255 keeps it high for the whole period.
- R5: A newly accepted duty takes effect only after the counter passes its ceiling at offset 255. The half-period before that still follows the previous duty.
- R6: A sample is taken on a clock where valid and ready are both high. Ready is low from the clock after a sample is taken until the clock after that sample is applied, which is offset 256 of the period in which it is applied. Values offered while ready is low are not taken.
- R7: Clearing the enable forces the output and the period pulse low from the next clock and clears the active duty to 0. After re-enable, the output stays low until a sample is applied, and the first pulse again comes 510 clocks later.
- R8: During synchronous reset, the output and the period pulse are low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; the counter advances once per clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Generator enable; low halts and clears the generator |
| duty_valid_i | input | 1 | Duty sample offered |
| duty_data_i | input | WIDTH | Unsigned duty sample |
| duty_ready_o | output | 1 | Holding stage is free to take a sample |
| pwm_o | output | 1 | Non-inverting PWM output |
| period_pulse_o | output | 1 | One-clock pulse when the counter arrives at zero |

## Verification
The bench builds the block with the default WIDTH of 8. This gives the true 510-clock period, and it puts both forced duties, 0 and 255, and the near-ceiling duty 254 within reach. Every offset of a period is sampled, so the bench checks the exact rising and falling positions of the output, not only its total high time. With this width the whole period is short enough to enumerate within the run. The bench can therefore also see the ceiling-aligned handover between an old duty and a new one, and the exact clock on which ready returns high.

// File: rtl/pwm_audio_pkg.sv
package pwm_audio_pkg;

  // Counting direction of the dual-slope counter.
  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;

endpackage

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter
  import pwm_audio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  output logic [WIDTH-1:0] cnt_o,
  output cnt_dir_e         dir_o,
  output logic             at_top_o,
  output logic             pulse_o
);

  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] cnt_q;
  cnt_dir_e         dir_q;
  logic             pulse_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      cnt_q   <= BOT;
      dir_q   <= CNT_UP;
      pulse_q <= 1'b0;
    end else begin
      // A pulse marks the clock in which the falling slope lands on zero.
      pulse_q <= (dir_q == CNT_DOWN) && (cnt_q == ONE);
      if (cnt_q == TOP) begin
        cnt_q <= TOP - ONE;
        dir_q <= CNT_DOWN;
      end else if (cnt_q == BOT) begin
        cnt_q <= ONE;
        dir_q <= CNT_UP;
      end else if (dir_q == CNT_UP) begin
        cnt_q <= cnt_q + ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
      end
    end
  end

  assign cnt_o    = cnt_q;
  assign dir_o    = dir_q;
  assign at_top_o = en_i && (cnt_q == TOP);
  assign pulse_o  = pulse_q;

  // R1: every enabled clock moves the count by exactly one step
  a_r1_single_step: assert property (@(posedge clk_i) disable iff (rst_i)
    ($past(en_i) && !$past(rst_i)) |->
      ((cnt_q == $past(cnt_q) + ONE) || (cnt_q == $past(cnt_q) - ONE)));

  // R1: the ceiling is left at once, with no dwell
  a_r1_turn_at_top: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && cnt_q == TOP) |=> (cnt_q == TOP - ONE));

  // R2: the period pulse lasts one clock and coincides with a zero count
  a_r2_pulse_one_wide: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_q |=> !pulse_q);

  a_r2_pulse_at_bottom: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_q |-> (cnt_q == BOT));

  // R7: a low enable clears the counter and the pulse
  a_r7_halt_clears: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> ((cnt_q == BOT) && !pulse_q));

endmodule

// File: rtl/pwm_duty_buffer.sv
module pwm_duty_buffer #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             at_top_i,
  input  logic             valid_i,
  input  logic [WIDTH-1:0] data_i,
  output logic             ready_o,
  output logic [WIDTH-1:0] act_o
);

  logic [WIDTH-1:0] pend_q;
  logic [WIDTH-1:0] act_q;
  logic             full_q;
  logic             take;
  logic             apply;

  assign take  = valid_i && !full_q;
  assign apply = at_top_i && full_q;

  // Holding stage: filled from the stream, emptied at the ceiling.
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pend_q <= '0;
      full_q <= 1'b0;
    end else if (take) begin
      pend_q <= data_i;
      full_q <= 1'b1;
    end else if (apply) begin
      full_q <= 1'b0;
    end
  end

  // Active stage: read by the comparator, replaced only at the ceiling.
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      act_q <= '0;
    end else if (apply) begin
      act_q <= pend_q;
    end
  end

  assign ready_o = !full_q;
  assign act_o   = act_q;

  // R6: a waiting sample is not overwritten by values offered meanwhile
  a_r6_hold_waiting: assert property (@(posedge clk_i) disable iff (rst_i)
    (full_q && !apply) |=> $stable(pend_q));

  // R6: the holding stage frees up on the clock after it is applied
  a_r6_ready_after_apply: assert property (@(posedge clk_i) disable iff (rst_i)
    apply |=> ready_o);

  // R5: the active duty changes only at the ceiling
  a_r5_swap_at_top: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !at_top_i) |=> $stable(act_q));

  // R7: a low enable clears the active duty
  a_r7_halt_zero_duty: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> (act_q == '0));

endmodule

// File: rtl/pwm_edge_compare.sv
module pwm_edge_compare
  import pwm_audio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic [WIDTH-1:0] cnt_i,
  input  cnt_dir_e         dir_i,
  input  logic [WIDTH-1:0] act_i,
  output logic             pwm_o
);

  localparam logic [WIDTH-1:0] TOP = '1;
  localparam logic [WIDTH-1:0] BOT = '0;

  logic pwm_q;
  logic mid_duty;

  assign mid_duty = (act_i != BOT) && (act_i != TOP);

  // Clear on the rising-slope match, set on the falling-slope match;
  // the two end values pin the output for the whole period.
  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      pwm_q <= 1'b0;
    end else if (act_i == BOT) begin
      pwm_q <= 1'b0;
    end else if (act_i == TOP) begin
      pwm_q <= 1'b1;
    end else if (cnt_i == act_i) begin
      pwm_q <= (dir_i == CNT_DOWN);
    end
  end

  assign pwm_o = pwm_q;

  // R3: with a mid-range duty the output moves only on a compare match
  a_r3_edge_only_on_match: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && mid_duty && (cnt_i != act_i)) |=> $stable(pwm_q));

  // R4: the end values pin the output
  a_r4_zero_duty_low: assert property (@(posedge clk_i) disable iff (rst_i)
    (act_i == BOT) |=> !pwm_q);

  a_r4_full_duty_high: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && act_i == TOP) |=> pwm_q);

endmodule

// File: rtl/pwm_audio_gen.sv
module pwm_audio_gen
  import pwm_audio_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             en_i,
  input  logic             duty_valid_i,
  input  logic [WIDTH-1:0] duty_data_i,
  output logic             duty_ready_o,
  output logic             pwm_o,
  output logic             period_pulse_o
);

  localparam int PERIOD = 2 * ((1 << WIDTH) - 1);
  localparam int GAP_W  = $clog2(PERIOD + 1) + 1;

  logic [WIDTH-1:0] cnt;
  cnt_dir_e         dir;
  logic             at_top;
  logic [WIDTH-1:0] act_duty;

  pwm_slope_counter #(.WIDTH(WIDTH)) u_counter (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .cnt_o    (cnt),
    .dir_o    (dir),
    .at_top_o (at_top),
    .pulse_o  (period_pulse_o)
  );

  pwm_duty_buffer #(.WIDTH(WIDTH)) u_buffer (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .en_i     (en_i),
    .at_top_i (at_top),
    .valid_i  (duty_valid_i),
    .data_i   (duty_data_i),
    .ready_o  (duty_ready_o),
    .act_o    (act_duty)
  );

  pwm_edge_compare #(.WIDTH(WIDTH)) u_compare (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .en_i  (en_i),
    .cnt_i (cnt),
    .dir_i (dir),
    .act_i (act_duty),
    .pwm_o (pwm_o)
  );

  // Clock count since the last pulse or since enable, for the R1 check.
  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      gap_q <= '0;
    end else if (period_pulse_o) begin
      gap_q <= GAP_W'(1);
    end else begin
      gap_q <= gap_q + GAP_W'(1);
    end
  end

  // R1/R2: each pulse, including the first after enable, lands one period on
  a_r1_period_spacing: assert property (@(posedge clk_i) disable iff (rst_i || !en_i)
    period_pulse_o |-> (gap_q == GAP_W'(PERIOD)));

  // R8: quiet outputs and a free holding stage after reset
  a_r8_reset_quiet: assert property (@(posedge clk_i)
    $past(rst_i) |-> (!pwm_o && !period_pulse_o && duty_ready_o));

endmodule

// File: tb/pwm_audio_gen_bench.sv
module pwm_audio_gen_bench;

  localparam int W    = 8;
  localparam int TOPV = (1 << W) - 1;
  localparam int PER  = 2 * TOPV;
  localparam int NV   = 8;
  localparam int VEC_DUTY [NV] = '{0, 1, 2, 37, 128, 200, 254, 255};
  localparam int VEC_HIGH [NV] = '{0, 2, 4, 74, 256, 400, 508, 510};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst;
  logic         en;
  logic         dv;
  logic [W-1:0] dd;
  logic         rdy;
  logic         pwm;
  logic         pls;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  pwm_audio_gen #(.WIDTH(W)) u_pwm_audio_gen (
    .clk_i          (clk),
    .rst_i          (rst),
    .en_i           (en),
    .duty_valid_i   (dv),
    .duty_data_i    (dd),
    .duty_ready_o   (rdy),
    .pwm_o          (pwm),
    .period_pulse_o (pls)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output bit ok);
    ok = 1'b0;
    for (int n = 0; n < 2000; n++) begin
      @(negedge clk);
      if (pls) begin
        ok = 1'b1;
        break;
      end
    end
  endtask

  task automatic load_duty(input int d);
    @(negedge clk);
    dv = 1'b1;
    dd = W'(d);
    while (!rdy) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    dv = 1'b0;
  endtask

  // Called at offset 0 (pulse high); samples every offset of one period.
  task automatic measure(input int d, input int exp_high);
    bit    samp [PER];
    int    highs = 0;
    int    extra = 0;
    string tag   = (d == 0 || d == TOPV) ? "R4" : "R3";
    for (int k = 0; k < PER; k++) begin
      samp[k] = pwm;
      if (pwm) highs++;
      if (k > 0 && pls) extra++;
      @(negedge clk);
    end
    check_eq("R1 next pulse one period on", int'(pls), 1);
    check_eq("R2 no pulse inside period", extra, 0);
    check_eq({tag, " high clocks per period"}, highs, exp_high);
    if (d >= 1 && d <= TOPV - 1) begin
      check_eq("R3 high at offset d", int'(samp[d]), 1);
      check_eq("R3 low at offset d+1", int'(samp[d + 1]), 0);
      if (d >= 2) begin
        check_eq("R3 low at offset 510-d", int'(samp[PER - d]), 0);
        check_eq("R3 high at offset 511-d", int'(samp[PER + 1 - d]), 1);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL R1 watchdog: actual %0d cycles expected fewer", 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ok;
    int n;
    int seen_high;
    rst = 1'b1;
    en  = 1'b0;
    dv  = 1'b0;
    dd  = '0;
    repeat (4) @(negedge clk);

    // R8: reset state
    check_eq("R8 pwm in reset", int'(pwm), 0);
    check_eq("R8 pulse in reset", int'(pls), 0);
    check_eq("R8 ready in reset", int'(rdy), 1);
    rst = 1'b0;
    @(negedge clk);
    check_eq("R7 pwm while disabled", int'(pwm), 0);

    // R2: first pulse 510 edges after enable; duty starts at zero (R7)
    en = 1'b1;
    n = 0;
    seen_high = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (pwm) seen_high++;
      if (pls) break;
    end
    check_eq("R2 edges to first pulse", n, PER);
    check_eq("R7 output low with zero duty after enable", seen_high, 0);

    // Vector table: steady duty, full period profile
    for (int i = 0; i < NV; i++) begin
      load_duty(VEC_DUTY[i]);
      wait_pulse(ok);
      check_eq("R1 pulse present", int'(ok), 1);
      wait_pulse(ok);
      check_eq("R1 pulse present", int'(ok), 1);
      measure(VEC_DUTY[i], VEC_HIGH[i]);
    end

    // R5/R6: ceiling-aligned handover and back-pressure
    load_duty(50);
    wait_pulse(ok);
    wait_pulse(ok);
    check_eq("R1 pulse present", int'(ok), 1);
    dv = 1'b1;
    dd = W'(100);
    @(negedge clk);
    dv = 1'b0;
    check_eq("R6 ready low after take", int'(rdy), 0);
    for (int k = 1; k < PER; k++) begin
      if (k == 51)  check_eq("R5 old duty still falls at 51", int'(pwm), 0);
      if (k == 100) begin
        dv = 1'b1;
        dd = W'(200);
      end
      if (k == 111) dv = 1'b0;
      if (k == 255) check_eq("R6 ready low before ceiling", int'(rdy), 0);
      if (k == 256) check_eq("R6 ready back after ceiling", int'(rdy), 1);
      if (k == 410) check_eq("R5 new duty low at 410", int'(pwm), 0);
      if (k == 411) check_eq("R5 new duty rises at 411", int'(pwm), 1);
      @(negedge clk);
    end
    check_eq("R1 pulse after handover period", int'(pls), 1);
    for (int k = 0; k <= 101; k++) begin
      if (k == 100) check_eq("R6 offered value ignored, high at 100", int'(pwm), 1);
      if (k == 101) check_eq("R6 offered value ignored, low at 101", int'(pwm), 0);
      if (k < 101) @(negedge clk);
    end
    check_eq("R6 ready idle", int'(rdy), 1);

    // R7: disable mid-high, then restart
    wait_pulse(ok);
    check_eq("R3 output high at pulse before halt", int'(pwm), 1);
    en = 1'b0;
    @(negedge clk);
    check_eq("R7 pwm cleared on halt", int'(pwm), 0);
    check_eq("R7 pulse cleared on halt", int'(pls), 0);
    seen_high = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pwm || pls) seen_high++;
    end
    check_eq("R7 outputs stay low while halted", seen_high, 0);
    en = 1'b1;
    n = 0;
    seen_high = 0;
    for (int i = 0; i < 2000; i++) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (pwm) seen_high++;
      if (pls) break;
    end
    check_eq("R7 restart edges to first pulse", n, PER);
    check_eq("R7 duty cleared by halt", seen_high, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule